// File: doc/BRIEF.md
# Hierarchical Binary Prefix Counter

This block takes a wide vector of one-bit predicates and works out, for every position, how many set predicates sit at lower indices (an exclusive running count). The vector is split into equal groups of lanes. The count inside a group is formed by masking the group's bits below the lane and taking a population count. The totals of the groups then go through a short word-level doubling scan, which gives each group the sum of all groups before it. A lane's final count is its in-group count plus that offset. The block also reports the number of set predicates in the whole vector.

The predicate vector is loaded in parallel with a one-cycle `start`. A small sequencer steps through three phases: a sweep that stores one group total per cycle, the doubling scan, and a closing step that latches the block total. Completion is signalled by a one-cycle `done`. After that, any lane's count can be read through an index port, which returns the value in the same cycle. With the default 32 lanes by 16 groups there are 512 predicates, and each count is 10 bits wide.

Top module: `bin_prefix_top`

## Requirements
- R1: Out of reset `done` is low and `total` is zero.
- R2: A `start` sampled while idle captures `pred_in`. `done` then goes high for exactly one cycle, on the 22nd rising edge after the edge that sampled `start`.
- R3: After `done`, `rd_cnt` for index k equals the number of set bits of the captured `pred_in` at indices below k. Bit k of `pred_in` is the predicate of lane k mod 32 in group k div 32.
- R4: After `done`, `total` equals the number of set bits in the captured vector.
- R5: A `start` that arrives while a computation is running is ignored. It changes neither the captured predicates nor the time at which `done` appears.
- R6: The first lane of each group reports the sum of the set predicates in all earlier groups. The first lane of group 0 always reports 0.
- R7: Between `done` and the next `start`, `total` and every `rd_cnt` value stay unchanged whatever `pred_in` does, and `done` stays low.
- R8: An all-zero vector gives zero at every index and a zero total. An all-one vector gives k at index k and a total of 512.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation on `pred_in` (taken only while idle) |
| pred_in | input | 512 | Predicate vector, bit k belongs to lane k mod 32 of group k div 32 |
| rd_idx | input | 9 | Index of the lane whose count is read |
| rd_cnt | output | 10 | Exclusive prefix count at `rd_idx` |
| total | output | 10 | Count of set predicates in the captured vector |
| done | output | 1 | One-cycle pulse when the results become valid |

## Verification
All-zero and all-one vectors pin down the two extremes: every count is zero, or every count equals its own index, so an off-by-one between exclusive and inclusive masking shows up at once. A vector with only the top lane of each group set isolates the group totals. Every first-lane read then depends purely on the scanned offsets, which exposes a wrong scan distance or a wrong offset index. Seeded random vectors cover mixed in-group and cross-group carries. A second `start` issued mid-run, and `pred_in` changes after completion, show that the captured data and the results do not move.

// File: rtl/bin_prefix_pkg.sv
package bin_prefix_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_GROUP   = 2'd1,
    ST_SCAN    = 2'd2,
    ST_COMBINE = 2'd3
  } bp_state_e;

  localparam int unsigned BP_LANES_DEF  = 32;
  localparam int unsigned BP_GROUPS_DEF = 16;

endpackage

// File: rtl/bin_prefix_lane_count.sv
// Masked population count over one group word.
// INCL=0 counts bits strictly below `lane`, INCL=1 counts bits up to and including it.
module bin_prefix_lane_count #(
  parameter int unsigned LANES = 32,
  parameter bit          INCL  = 1'b0,
  localparam int unsigned LW   = $clog2(LANES),
  localparam int unsigned LCW  = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] word,
  input  logic [LW-1:0]    lane,
  output logic [LCW-1:0]   cnt
);

  logic [LANES-1:0] mask;

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    if (INCL) begin : g_le
      assign mask[i] = (LW'(i) <= lane);
    end else begin : g_lt
      assign mask[i] = (LW'(i) < lane);
    end
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < LANES; i++) begin
      cnt = cnt + LCW'(word[i] & mask[i]);
    end
  end

endmodule

// File: rtl/bin_prefix_word_scan.sv
// Table of group totals with an in-place doubling (inclusive) scan.
// The scan network is LANES wide in distance (1,2,4,...); only GROUPS entries are stored.
module bin_prefix_word_scan #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned GROUPS = 16,
  parameter int unsigned CW     = 10,
  parameter int unsigned SELW   = 5,
  localparam int unsigned GW    = $clog2(GROUPS),
  localparam int unsigned STEPS = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 wr_en,
  input  logic [GW-1:0]        wr_idx,
  input  logic [CW-1:0]        wr_val,
  input  logic                 step_en,
  input  logic [SELW-1:0]      step,
  output logic [GROUPS*CW-1:0] tbl_flat
);

  logic [CW-1:0] tbl_q [GROUPS];

  for (genvar i = 0; i < GROUPS; i++) begin : g_entry
    logic [CW-1:0] contrib [STEPS];
    logic [CW-1:0] add_v;
    logic [CW-1:0] tbl_d;
    logic          tbl_en;

    // Each step reads the entry `1<<s` below; indices under zero read as zero.
    for (genvar s = 0; s < STEPS; s++) begin : g_dist
      if (i >= (1 << s)) begin : g_reach
        assign contrib[s] = (step == SELW'(s)) ? tbl_q[i - (1 << s)] : '0;
      end else begin : g_none
        assign contrib[s] = '0;
      end
    end

    always_comb begin
      add_v = '0;
      for (int s = 0; s < STEPS; s++) begin
        add_v = add_v | contrib[s];
      end
    end

    always_comb begin
      tbl_en = clr | (wr_en && (wr_idx == GW'(i))) | step_en;
      if (clr) begin
        tbl_d = '0;
      end else if (wr_en) begin
        tbl_d = wr_val;
      end else begin
        tbl_d = tbl_q[i] + add_v;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl_q[i] <= '0;
      end else if (tbl_en) begin
        tbl_q[i] <= tbl_d;
      end
    end

    assign tbl_flat[i*CW +: CW] = tbl_q[i];
  end

endmodule

// File: rtl/bin_prefix_ctrl.sv
// Phase sequencer: IDLE -> GROUP (one group per cycle) -> SCAN (one step per cycle) -> COMBINE.
module bin_prefix_ctrl
  import bin_prefix_pkg::*;
#(
  parameter int unsigned LANES  = 32,
  parameter int unsigned GROUPS = 16,
  localparam int unsigned GW    = $clog2(GROUPS),
  localparam int unsigned LW    = $clog2(LANES),
  localparam int unsigned STEPS = LW,
  localparam int unsigned CNTW  = (GW > LW) ? GW : LW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            load,
  output logic            wr_en,
  output logic [GW-1:0]   grp_idx,
  output logic            step_en,
  output logic [CNTW-1:0] step,
  output logic            total_en,
  output logic            done,
  output logic            busy,
  output logic            res_valid
);

  bp_state_e       state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            done_q, done_d;
  logic            valid_q, valid_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_GROUP;
          cnt_d   = '0;
        end
      end
      ST_GROUP: begin
        if (cnt_q == CNTW'(GROUPS - 1)) begin
          state_d = ST_SCAN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SCAN: begin
        if (cnt_q == CNTW'(STEPS - 1)) begin
          state_d = ST_COMBINE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_COMBINE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign load     = (state_q == ST_IDLE) && start;
  assign wr_en    = (state_q == ST_GROUP);
  assign step_en  = (state_q == ST_SCAN);
  assign total_en = (state_q == ST_COMBINE);
  assign grp_idx  = cnt_q[GW-1:0];
  assign step     = cnt_q;
  assign busy     = (state_q != ST_IDLE);

  always_comb begin
    done_d  = (state_q == ST_COMBINE);
    valid_d = valid_q;
    if (load) begin
      valid_d = 1'b0;
    end else if (state_q == ST_COMBINE) begin
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      valid_q <= valid_d;
    end
  end

  assign done      = done_q;
  assign res_valid = valid_q;

endmodule

// File: rtl/bin_prefix_top.sv
module bin_prefix_top #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned GROUPS = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  input  logic [LANES*GROUPS-1:0]                pred_in,
  input  logic [$clog2(LANES*GROUPS)-1:0]        rd_idx,
  output logic [$clog2(LANES*GROUPS+1)-1:0]      rd_cnt,
  output logic [$clog2(LANES*GROUPS+1)-1:0]      total,
  output logic                                   done
);

  localparam int unsigned N_PRED = LANES * GROUPS;
  localparam int unsigned LW     = $clog2(LANES);
  localparam int unsigned GW     = $clog2(GROUPS);
  localparam int unsigned IW     = LW + GW;
  localparam int unsigned CW     = $clog2(N_PRED + 1);
  localparam int unsigned LCW    = $clog2(LANES + 1);
  localparam int unsigned CNTW   = (GW > LW) ? GW : LW;

  // Control
  logic            load, wr_en, step_en, total_en, busy, res_valid;
  logic [GW-1:0]   grp_idx;
  logic [CNTW-1:0] step;

  bin_prefix_ctrl #(.LANES(LANES), .GROUPS(GROUPS)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .load     (load),
    .wr_en    (wr_en),
    .grp_idx  (grp_idx),
    .step_en  (step_en),
    .step     (step),
    .total_en (total_en),
    .done     (done),
    .busy     (busy),
    .res_valid(res_valid)
  );

  // Captured predicates
  logic [N_PRED-1:0] pred_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= '0;
    end else if (load) begin
      pred_q <= pred_in;
    end
  end

  // Group sweep: total of the selected group = inclusive count at its last lane
  logic [LANES-1:0] grp_word;
  logic [LCW-1:0]   grp_total;

  assign grp_word = pred_q[{grp_idx, {LW{1'b0}}} +: LANES];

  bin_prefix_lane_count #(.LANES(LANES), .INCL(1'b1)) i_grp_total (
    .word(grp_word),
    .lane(LW'(LANES - 1)),
    .cnt (grp_total)
  );

  // Table of group totals, scanned in place
  logic [GROUPS*CW-1:0] tbl_flat;

  bin_prefix_word_scan #(
    .LANES (LANES),
    .GROUPS(GROUPS),
    .CW    (CW),
    .SELW  (CNTW)
  ) i_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (load),
    .wr_en   (wr_en),
    .wr_idx  (grp_idx),
    .wr_val  (CW'(grp_total)),
    .step_en (step_en),
    .step    (step),
    .tbl_flat(tbl_flat)
  );

  // Block total
  logic [CW-1:0] total_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
    end else if (total_en) begin
      total_q <= tbl_flat[(GROUPS-1)*CW +: CW];
    end
  end

  assign total = total_q;

  // Indexed read: in-group exclusive count plus offset of earlier groups
  logic [GW-1:0]    rd_grp, prev_grp;
  logic [LW-1:0]    rd_lane;
  logic [LANES-1:0] rd_word;
  logic [LCW-1:0]   rd_in_grp;
  logic [CW-1:0]    rd_offset;

  assign rd_grp   = rd_idx[IW-1:LW];
  assign rd_lane  = rd_idx[LW-1:0];
  assign prev_grp = rd_grp - GW'(1);
  assign rd_word  = pred_q[{rd_grp, {LW{1'b0}}} +: LANES];

  bin_prefix_lane_count #(.LANES(LANES), .INCL(1'b0)) i_rd_count (
    .word(rd_word),
    .lane(rd_lane),
    .cnt (rd_in_grp)
  );

  always_comb begin
    if (rd_grp == '0) begin
      rd_offset = '0;
    end else begin
      rd_offset = tbl_flat[prev_grp*CW +: CW];
    end
  end

  assign rd_cnt = rd_offset + CW'(rd_in_grp);

endmodule

// File: rtl/bin_prefix_checker.sv
module bin_prefix_checker #(
  parameter int unsigned N_PRED = 512,
  parameter int unsigned CW     = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              busy,
  input logic              res_valid,
  input logic [CW-1:0]     total,
  input logic [CW-1:0]     rd_cnt,
  input logic [N_PRED-1:0] pred_q
);

  // R2: completion pulse lasts one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: completion is reported with the sequencer back at idle
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5: captured predicates cannot change while a computation runs
  a_r5_pred_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pred_q));

  // R4: block total never exceeds the number of predicates
  a_r4_total_range: assert property (@(posedge clk) disable iff (!rst_n)
    total <= CW'(N_PRED));

  // R3: an exclusive count never exceeds the block total
  a_r3_rd_bound: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (rd_cnt <= total));

  // R7: total only moves at the end of a computation
  a_r7_total_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(total));

endmodule

bind bin_prefix_top bin_prefix_checker #(.N_PRED(N_PRED), .CW(CW)) i_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .done     (done),
  .busy     (busy),
  .res_valid(res_valid),
  .total    (total),
  .rd_cnt   (rd_cnt),
  .pred_q   (pred_q)
);

// File: tb/test_bin_prefix_top.sv
module test_bin_prefix_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 32;
  localparam int GROUPS = 16;
  localparam int N      = LANES * GROUPS;
  localparam int IW     = $clog2(N);
  localparam int CW     = $clog2(N + 1);
  localparam int EXP_LAT = 23; // edges counted including the sampling edge

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [N-1:0]  pred_in;
  logic [IW-1:0] rd_idx;
  logic [CW-1:0] rd_cnt;
  logic [CW-1:0] total;
  logic          done;

  int checks;
  int failures;

  bin_prefix_top #(.LANES(LANES), .GROUPS(GROUPS)) i_bin_prefix_top (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .pred_in(pred_in),
    .rd_idx (rd_idx),
    .rd_cnt (rd_cnt),
    .total  (total),
    .done   (done)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ones(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  // Launch a computation; optionally fire a second start mid-run with other data.
  task automatic launch(input logic [N-1:0] pat, input bit inject, input logic [N-1:0] other,
                        output int lat);
    @(negedge clk);
    pred_in = pat;
    start   = 1'b1;
    lat     = 0;
    while (lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
      if (inject && lat == 5) begin
        pred_in = other;
        start   = 1'b1;
      end
      if (done) break;
    end
    start = 1'b0;
  endtask

  // R3: compare every index against a serial running count
  task automatic verify_all(input string req, input logic [N-1:0] pat);
    int run = 0;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      rd_idx = IW'(k);
      #1;
      chk(req, $sformatf("index %0d", k), int'(rd_cnt), run);
      run += int'(pat[k]);
    end
    chk("R4", "total", int'(total), ones(pat));
  endtask

  task automatic run_pattern(input string req, input logic [N-1:0] pat);
    int lat;
    launch(pat, 1'b0, '0, lat);
    chk("R2", "done latency", lat, EXP_LAT);
    @(negedge clk);
    chk("R2", "done width", int'(done), 0);
    verify_all(req, pat);
  endtask

  task automatic t_reset;
    rst_n   = 1'b0;
    start   = 1'b0;
    pred_in = '0;
    rd_idx  = '0;
    repeat (3) @(negedge clk);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "total after reset", int'(total), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_zeros;
    run_pattern("R8", '0);
  endtask

  task automatic t_ones;
    run_pattern("R8", '1);
  endtask

  // R6: only the last lane of each group set; first lanes must see g counts
  task automatic t_group_edges;
    logic [N-1:0] pat = '0;
    int lat;
    for (int g = 0; g < GROUPS; g++) pat[g*LANES + LANES - 1] = 1'b1;
    launch(pat, 1'b0, '0, lat);
    chk("R2", "done latency", lat, EXP_LAT);
    for (int g = 0; g < GROUPS; g++) begin
      @(negedge clk);
      rd_idx = IW'(g * LANES);
      #1;
      chk("R6", $sformatf("first lane of group %0d", g), int'(rd_cnt), g);
    end
    verify_all("R6", pat);
  endtask

  task automatic t_random(input int seed_rounds);
    logic [N-1:0] pat;
    for (int r = 0; r < seed_rounds; r++) begin
      for (int w = 0; w < N / 32; w++) pat[w*32 +: 32] = $urandom;
      run_pattern("R3", pat);
    end
  endtask

  // R5: second start while running is ignored
  task automatic t_busy_start;
    logic [N-1:0] pat_a, pat_b;
    int lat;
    for (int w = 0; w < N / 32; w++) begin
      pat_a[w*32 +: 32] = $urandom;
      pat_b[w*32 +: 32] = ~pat_a[w*32 +: 32];
    end
    launch(pat_a, 1'b1, pat_b, lat);
    chk("R5", "done latency with extra start", lat, EXP_LAT);
    verify_all("R5", pat_a);
  endtask

  // R7: results hold after done while pred_in moves and no start is given
  task automatic t_hold;
    logic [N-1:0] pat;
    int lat;
    int seen_done = 0;
    for (int w = 0; w < N / 32; w++) pat[w*32 +: 32] = $urandom;
    launch(pat, 1'b0, '0, lat);
    chk("R2", "done latency", lat, EXP_LAT);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      pred_in = ~pred_in;
      if (done) seen_done++;
    end
    chk("R7", "done pulses while idle", seen_done, 0);
    verify_all("R7", pat);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    t_reset();
    t_zeros();
    t_ones();
    t_group_edges();
    t_random(3);
    t_busy_start();
    t_hold();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule